// File: doc/BRIEF.md
# Hoisted-Load Conflict Table

This block tracks loads that a scheduler has moved above earlier stores. When such a load issues early, it records its destination tag and its 8-byte word address in a small fully associative table. Every later store searches the table by word address and flags any entry it hits. When the program reaches the point where the load originally sat, a check asks the table, by tag, whether the early value can be kept. If the value is stale or the entry is missing, the check reports that the load must be run again. The entry is then released.

The three ports carry no back-pressure. Insert, store and check requests are plain pulses qualified by a valid bit, and each is accepted in the cycle it is presented. The table never stalls. When it is full, it frees room by evicting entries through a victim pointer that rotates over the slots.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset the table is empty. A check of any tag then reports `chk_found`=0 and `chk_redo`=1.
- R2: A check of a tag that was inserted and not touched since reports `chk_found`=1 and `chk_redo`=0.
- R3: A store whose address falls in the same 8-byte word as a valid entry (address bits above bit 2 equal) marks that entry. A later check of its tag reports `chk_redo`=1.
- R4: A store to a different 8-byte word has no effect on an entry. Its check still reports `chk_found`=1 and `chk_redo`=0.
- R5: An insert and a store presented in the same cycle act as if the insert came first. A store to the new entry's word marks that entry.
- R6: A check releases the entry it finds, whatever its result. A second check of the same tag reports `chk_found`=0 and `chk_redo`=1, and any check that finds no entry reports `chk_redo`=1.
- R7: Each tag has at most one entry. Inserting a tag that is already present overwrites that entry's address and clears its mark. A store to the old address no longer affects it.
- R8: Inserts fill free slots from the lowest index up. When all 8 slots are valid, a new tag replaces the slot under a victim pointer. The pointer starts at slot 0 and advances by one after each eviction. An evicted tag's check reports a miss.
- R9: `chk_found` and `chk_redo` are combinational from `chk_valid`/`chk_tag` and the table state in the same cycle. Both outputs are 0 while `chk_valid` is 0.
- R10: A check and an insert of the same tag in one cycle proceed as follows. The check reports the old entry. The insert then leaves a fresh, valid, unmarked entry for that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Insert request from an early load |
| ld_tag | input | TAG_W (7) | Destination tag of the early load |
| ld_addr | input | ADDR_W (32) | Byte address of the early load |
| st_valid | input | 1 | Store search request |
| st_addr | input | ADDR_W (32) | Byte address of the store |
| chk_valid | input | 1 | Check request |
| chk_tag | input | TAG_W (7) | Tag being checked |
| chk_found | output | 1 | An entry for `chk_tag` exists |
| chk_redo | output | 1 | The load must be executed again |

## Verification
A check result is due in the same cycle as its request. Any insert, store or release becomes visible to a check presented one cycle later. The bench changes inputs shortly after a rising edge. A monitor compares the two check outputs at the following falling edge against the head of a scoreboard queue. Each state change is therefore observed by the first check that may legally see it, and never by one that may not.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [1:0] {
    ALLOC_NONE  = 2'd0,
    ALLOC_REUSE = 2'd1,
    ALLOC_FREE  = 2'd2,
    ALLOC_EVICT = 2'd3
  } alloc_kind_e;
endpackage

// File: rtl/slt_first_set.sv
module slt_first_set #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/slt_match_bank.sv
module slt_match_bank #(
  parameter int N      = 8,
  parameter int TAG_W  = 7,
  parameter int WORD_W = 29
) (
  input  logic [N-1:0]             valid_q,
  input  logic [N-1:0][TAG_W-1:0]  tag_q,
  input  logic [N-1:0][WORD_W-1:0] word_q,
  input  logic [TAG_W-1:0]         ld_tag,
  input  logic [TAG_W-1:0]         chk_tag,
  input  logic [WORD_W-1:0]        st_word,
  output logic [N-1:0]             ld_hit,
  output logic [N-1:0]             chk_hit,
  output logic [N-1:0]             st_hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign ld_hit[i]  = valid_q[i] && (tag_q[i]  == ld_tag);
    assign chk_hit[i] = valid_q[i] && (tag_q[i]  == chk_tag);
    assign st_hit[i]  = valid_q[i] && (word_q[i] == st_word);
  end
endmodule

// File: rtl/slt_alloc.sv
module slt_alloc
  import slt_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_valid,
  input  logic [N-1:0] ld_hit,
  input  logic [N-1:0] valid_q,
  output logic [N-1:0] wr_sel
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] victim_q;
  logic [N-1:0]     free_sel;
  logic             free_any;
  logic [N-1:0]     victim_oh;
  alloc_kind_e      kind;

  slt_first_set #(.N(N)) u_free (
    .req   (~valid_q),
    .grant (free_sel),
    .any   (free_any)
  );

  assign victim_oh = N'(1) << victim_q;

  always_comb begin
    kind   = ALLOC_NONE;
    wr_sel = '0;
    if (ld_valid) begin
      if (|ld_hit) begin
        kind   = ALLOC_REUSE;
        wr_sel = ld_hit;
      end else if (free_any) begin
        kind   = ALLOC_FREE;
        wr_sel = free_sel;
      end else begin
        kind   = ALLOC_EVICT;
        wr_sel = victim_oh;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_q <= '0;
    end else if (kind == ALLOC_EVICT) begin
      victim_q <= (victim_q == IDX_W'(N - 1)) ? '0 : victim_q + 1'b1;
    end
  end
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
  parameter int ENTRIES    = 8,
  parameter int TAG_W      = 7,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              chk_found,
  output logic              chk_redo
);
  localparam int WORD_W = ADDR_W - ALIGN_BITS;

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             viol_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][WORD_W-1:0] word_q;

  logic [WORD_W-1:0]  ld_word;
  logic [WORD_W-1:0]  st_word;
  logic [ENTRIES-1:0] ld_hit;
  logic [ENTRIES-1:0] chk_hit;
  logic [ENTRIES-1:0] st_hit;
  logic [ENTRIES-1:0] wr_sel;
  logic               new_marked;

  assign ld_word = ld_addr[ADDR_W-1:ALIGN_BITS];
  assign st_word = st_addr[ADDR_W-1:ALIGN_BITS];

  slt_match_bank #(.N(ENTRIES), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_match (
    .valid_q (valid_q),
    .tag_q   (tag_q),
    .word_q  (word_q),
    .ld_tag  (ld_tag),
    .chk_tag (chk_tag),
    .st_word (st_word),
    .ld_hit  (ld_hit),
    .chk_hit (chk_hit),
    .st_hit  (st_hit)
  );

  slt_alloc #(.N(ENTRIES)) u_alloc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_hit   (ld_hit),
    .valid_q  (valid_q),
    .wr_sel   (wr_sel)
  );

  // Check result: combinational, from pre-update state.
  assign chk_found = chk_valid && (|chk_hit);
  assign chk_redo  = chk_valid && (!(|chk_hit) || (|(chk_hit & viol_q)));

  // A store in the same cycle sees the new entry (insert first).
  assign new_marked = st_valid && (st_word == ld_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      viol_q  <= '0;
      tag_q   <= '0;
      word_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (st_valid && st_hit[i]) viol_q[i] <= 1'b1;
        if (chk_valid && chk_hit[i]) valid_q[i] <= 1'b0;
        if (ld_valid && wr_sel[i]) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= ld_tag;
          word_q[i]  <= ld_word;
          viol_q[i]  <= new_marked;
        end
      end
    end
  end
endmodule

// File: rtl/slt_checker.sv
module slt_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_valid,
  input logic         st_valid,
  input logic         chk_valid,
  input logic         chk_found,
  input logic         chk_redo,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] viol_q,
  input logic [N-1:0] ld_hit,
  input logic [N-1:0] st_hit
);
  // R6
  miss_redo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_found) |-> chk_redo);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> (!chk_found && !chk_redo));

  // R7
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_hit));

  // R6
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_found && !ld_valid) |=>
      ($countones(valid_q) == $past($countones(valid_q)) - 1));

  // R3
  store_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !ld_valid && !chk_valid) |=>
      ((viol_q & $past(st_hit)) == $past(st_hit)));

  // R8
  fill_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !chk_valid && !(|ld_hit) && !(&valid_q)) |=>
      ($countones(valid_q) == $past($countones(valid_q)) + 1));
endmodule

bind spec_load_tracker slt_checker #(.N(ENTRIES)) u_slt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .st_valid  (st_valid),
  .chk_valid (chk_valid),
  .chk_found (chk_found),
  .chk_redo  (chk_redo),
  .valid_q   (valid_q),
  .viol_q    (viol_q),
  .ld_hit    (ld_hit),
  .st_hit    (st_hit)
);

// File: tb/spec_load_tracker_bench.sv
`timescale 1ns/1ps
module spec_load_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [6:0]  ld_tag = '0;
  logic [31:0] ld_addr = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic        chk_valid = 1'b0;
  logic [6:0]  chk_tag = '0;
  logic        chk_found;
  logic        chk_redo;

  typedef struct {
    bit    found;
    bit    redo;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  spec_load_tracker u_spec_load_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_tag    (ld_tag),
    .ld_addr   (ld_addr),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .chk_valid (chk_valid),
    .chk_tag   (chk_tag),
    .chk_found (chk_found),
    .chk_redo  (chk_redo)
  );

  // One cycle of stimulus; a check pushes its expected result.
  task automatic cyc(input bit lv, input int lt, input int la,
                     input bit sv, input int sa,
                     input bit cv, input int ct,
                     input bit ef, input bit er, input string req);
    exp_t e;
    ld_valid = lv; ld_tag = 7'(lt); ld_addr = 32'(la);
    st_valid = sv; st_addr = 32'(sa);
    chk_valid = cv; chk_tag = 7'(ct);
    if (cv) begin
      e.found = ef; e.redo = er; e.req = req;
      exp_q.push_back(e);
    end
    @(posedge clk);
    #1;
    ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
  endtask

  task automatic ins(input int t, input int a);
    cyc(1, t, a, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic sto(input int a);
    cyc(0, 0, 0, 1, a, 0, 0, 0, 0, "");
  endtask
  task automatic chk(input int t, input bit ef, input bit er, input string req);
    cyc(0, 0, 0, 0, 0, 1, t, ef, er, req);
  endtask

  // Monitor: compare at the falling edge, away from the update edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_valid) begin
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL unexpected check: found=%0b redo=%0b", chk_found, chk_redo);
        end else begin
          e = exp_q.pop_front();
          if (chk_found !== e.found || chk_redo !== e.redo) begin
            failures++;
            $display("FAIL %s: found=%0b redo=%0b expected found=%0b redo=%0b",
                     e.req, chk_found, chk_redo, e.found, e.redo);
          end
        end
      end else begin
        checks++;
        if (chk_found !== 1'b0 || chk_redo !== 1'b0) begin
          failures++;
          $display("FAIL R9 idle: found=%0b redo=%0b expected found=0 redo=0",
                   chk_found, chk_redo);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: empty after reset
    chk(5, 0, 1, "R1 empty table");
    // R2 / R9: clean entry, same-cycle result
    ins(5, 'h100);
    chk(5, 1, 0, "R2 clean entry");
    chk(99, 0, 1, "R6 unknown tag");
    // R3: same word, different byte offset
    ins(6, 'h200);
    sto('h207);
    chk(6, 1, 1, "R3 store same word");
    // R4: neighbouring words
    ins(7, 'h300);
    sto('h308);
    sto('h2F8);
    chk(7, 1, 0, "R4 store other word");
    // R5: insert and store together
    cyc(1, 8, 'h400, 1, 'h404, 0, 0, 0, 0, "");
    chk(8, 1, 1, "R5 same-cycle store");
    // R6: check consumes entry
    ins(9, 'h500);
    chk(9, 1, 0, "R6 first check");
    chk(9, 0, 1, "R6 second check");
    // R7: reinsert clears mark and moves address
    ins(10, 'h600);
    sto('h600);
    ins(10, 'h700);
    chk(10, 1, 0, "R7 reinsert clears mark");
    ins(10, 'h600);
    ins(10, 'h700);
    sto('h600);
    chk(10, 1, 0, "R7 old address ignored");
    ins(10, 'h700);
    sto('h700);
    chk(10, 1, 1, "R7 new address matched");
    // R8: fill and evict round robin
    for (int i = 0; i < 8; i++) ins(20 + i, 'h1000 + i * 16);
    ins(28, 'h2000);
    ins(29, 'h2010);
    chk(20, 0, 1, "R8 first victim evicted");
    chk(21, 0, 1, "R8 second victim evicted");
    chk(22, 1, 0, "R8 survivor");
    chk(28, 1, 0, "R8 new entry");
    chk(29, 1, 0, "R8 new entry");
    for (int i = 23; i < 28; i++) chk(i, 1, 0, "R8 survivors");
    // R10: check and insert of same tag together
    ins(40, 'h3000);
    cyc(1, 40, 'h4000, 0, 0, 1, 40, 1, 0, "R10 check sees old entry");
    sto('h3000);
    chk(40, 1, 0, "R10 fresh entry unmarked");
    ins(41, 'h5000);
    sto('h5000);
    cyc(1, 41, 'h6000, 0, 0, 1, 41, 1, 1, "R10 old mark reported");
    chk(41, 1, 0, "R10 mark cleared");
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d pending, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule